// File: doc/BRIEF.md
# Page-Table Refill Descriptor Engine

This block rewrites entries of a two-dimensional translation lookup table that is organised as a grid of slots, 256 columns by 128 rows. Software places a chain of descriptors in memory and writes the address of the first one into the pointer register. The engine fetches each descriptor over a simple read port and checks it. It then streams the descriptor's data array, one 32-bit physical-address entry per slot, into the table RAM through a write port. It fills the descriptor's rectangle row by row and then follows the next-descriptor pointer.

A descriptor is five words at a 16-byte aligned address:

| Byte offset | Content |
|---|---|
| +0 | next-descriptor pointer (zero ends the chain) |
| +4 | x0 in bits [15:0], y0 in bits [31:16] |
| +8 | x1 in bits [15:0], y1 in bits [31:16] (bounds inclusive) |
| +12 | control word: bit 0 is the start flag, bits [11:8] the table identifier |
| +16 | data pointer |

The register file has five entries, selected by `reg_addr`:

| `reg_addr` | Register |
|---|---|
| 0 | descriptor pointer |
| 1 | status: bit 0 READY, bit 1 ERR |
| 2 | interrupt status (one 8-bit field per engine; this block has one engine, so bits [7:0], bit 0 = chain done) |
| 3 | interrupt enable |
| 4 | hardware info |

Top module: `tfill_engine`

## Requirements
- R1: After reset the status register reads READY=1 and ERR=0, the interrupt status reads 0, `irq` is low and no table write occurs.
- R2: The hardware-info register (address 4) reads the engine count (1) in bits [28:24], the table count (NUM_TABLES, default 2) in bits [20:16], and zero in all other bits.
- R3: Writing a nonzero, 16-byte aligned value to the pointer register (address 0) while READY=1 starts a walk at that address, clears ERR and drops READY until the walk ends.
- R4: The entries of a descriptor's data array are written in row-major order. Entry k goes to slot x0+(k mod w), y0+(k div w), where w=x1-x0+1. The write address is y*256+x, the table identifier port carries control bits [11:8], and the data is the k-th 32-bit word at the data pointer.
- R5: After a descriptor is filled, the engine fetches the descriptor at its next pointer. A next pointer of zero ends the chain.
- R6: When a chain ends normally, READY returns to 1, ERR stays 0 and interrupt status bit 0 is set.
- R7: A descriptor is rejected if its start flag is clear, x0>x1, y0>y1, x1>255, y1>127, its table identifier is NUM_TABLES or more, or its data pointer is not 16-byte aligned. A rejected descriptor causes no table write, sets ERR, returns to READY and does not set the done bit.
- R8: A nonzero pointer write, or a nonzero next pointer, whose low four bits are not zero sets ERR and ends the walk without a done bit.
- R9: Writing zero to the pointer register aborts any walk: at most one further table write follows, READY is 1 on the next cycle, ERR is cleared and no done bit is set.
- R10: `irq` is high exactly when some interrupt status bit and its interrupt enable bit (address 3) are both 1.
- R11: Writing 1 to an interrupt status bit clears it; writing 0 leaves it unchanged.
- R12: A nonzero pointer write while READY=0 is ignored; the walk in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register select |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | read data of the selected register (combinational) |
| mem_rd_en | output | 1 | memory read request |
| mem_rd_addr | output | 32 | memory byte address, word aligned |
| mem_rd_data | input | 32 | memory read data, valid one cycle after the request |
| tbl_we | output | 1 | table write strobe |
| tbl_id | output | TID_W (4) | table identifier of the write |
| tbl_addr | output | XW+YW (15) | slot index y*256+x |
| tbl_wdata | output | 32 | entry written into the slot |
| irq | output | 1 | interrupt request |

## Verification
The assertions assume that memory returns read data exactly one cycle after `mem_rd_en`, with no stall. They also assume that no register other than the pointer is written while a data array is being streamed, so that a done event is never masked by a concurrent acknowledge. The bench's memory model answers every request with fixed one-cycle latency. It keeps descriptors, data arrays and the abort target in disjoint memory regions, and touches the interrupt registers only while the engine is READY. This holds except for the deliberate pointer writes in the abort and busy-ignore tests.

// File: rtl/tfill_pkg.sv
package tfill_pkg;
   typedef enum logic [2:0] {
      WS_IDLE,
      WS_FETCH,
      WS_CHECK,
      WS_FILL,
      WS_LAST
   } walk_state_e;

   localparam int DESC_WORDS = 5;

   localparam logic [2:0] RA_PTR  = 3'd0;
   localparam logic [2:0] RA_STAT = 3'd1;
   localparam logic [2:0] RA_IRQS = 3'd2;
   localparam logic [2:0] RA_IRQE = 3'd3;
   localparam logic [2:0] RA_INFO = 3'd4;

   localparam int STAT_READY = 0;
   localparam int STAT_ERR   = 1;
   localparam int IRQ_DONE   = 0;
endpackage

// File: rtl/tfill_raster.sv
module tfill_raster #(
   parameter int XW = 8,
   parameter int YW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [XW-1:0] x0,
   input  logic [XW-1:0] x1,
   input  logic [YW-1:0] y0,
   input  logic [YW-1:0] y1,
   output logic [XW-1:0] cx,
   output logic [YW-1:0] cy,
   output logic          last
);
   assign last = (cx == x1) && (cy == y1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cx <= '0;
         cy <= '0;
      end else if (load) begin
         cx <= x0;
         cy <= y0;
      end else if (step && !last) begin
         if (cx == x1) begin
            cx <= x0;
            cy <= cy + YW'(1);
         end else begin
            cx <= cx + XW'(1);
         end
      end
   end

   // R4: each step moves one slot right, or wraps to x0 on the next row
   assert_raster_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !last) |=>
         ((cx == $past(cx) + XW'(1)) && (cy == $past(cy))) ||
         ((cx == x0) && (cy == $past(cy) + YW'(1))));
endmodule

// File: rtl/tfill_walker.sv
module tfill_walker
   import tfill_pkg::*;
#(
   parameter int XW         = 8,
   parameter int YW         = 7,
   parameter int TID_W      = 4,
   parameter int NUM_TABLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             clear,
   input  logic [31:0]      go_ptr,
   output logic             mem_rd_en,
   output logic [31:0]      mem_rd_addr,
   input  logic [31:0]      mem_rd_data,
   output logic             tbl_we,
   output logic [TID_W-1:0] tbl_id,
   output logic [XW+YW-1:0] tbl_addr,
   output logic [31:0]      tbl_wdata,
   output logic             ready,
   output logic             err,
   output logic             done_pulse,
   output logic [31:0]      cur_ptr
);
   localparam logic [16:0]      LIM_X = 17'(1 << XW);
   localparam logic [16:0]      LIM_Y = 17'(1 << YW);
   localparam logic [TID_W:0]   LIM_T = (TID_W + 1)'(NUM_TABLES);
   localparam logic [2:0]       LAST_W = 3'(DESC_WORDS);

   walk_state_e   state;
   logic [31:0]   dw [DESC_WORDS];
   logic [2:0]    fcnt;
   logic [31:0]   ptr;
   logic [31:0]   dptr;
   logic          wr_pend;
   logic [XW-1:0] wr_x;
   logic [YW-1:0] wr_y;
   logic [XW-1:0] cx;
   logic [YW-1:0] cy;
   logic          last;

   logic [15:0]      f_x0, f_y0, f_x1, f_y1;
   logic [TID_W-1:0] f_tid;
   logic             desc_ok;

   assign f_x0  = dw[1][15:0];
   assign f_y0  = dw[1][31:16];
   assign f_x1  = dw[2][15:0];
   assign f_y1  = dw[2][31:16];
   assign f_tid = dw[3][8 +: TID_W];

   assign desc_ok = dw[3][0]
                 && (f_x0 <= f_x1) && (f_y0 <= f_y1)
                 && ({1'b0, f_x1} < LIM_X) && ({1'b0, f_y1} < LIM_Y)
                 && ({1'b0, f_tid} < LIM_T)
                 && (dw[4][3:0] == 4'h0);

   logic unused_ctrl_bits;
   assign unused_ctrl_bits = ^{dw[3][31:8+TID_W], dw[3][7:1]};

   tfill_raster #(.XW(XW), .YW(YW)) i_raster (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (state == WS_CHECK && desc_ok),
      .step  (state == WS_FILL),
      .x0    (f_x0[XW-1:0]),
      .x1    (f_x1[XW-1:0]),
      .y0    (f_y0[YW-1:0]),
      .y1    (f_y1[YW-1:0]),
      .cx    (cx),
      .cy    (cy),
      .last  (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= WS_IDLE;
         fcnt       <= '0;
         ptr        <= '0;
         dptr       <= '0;
         err        <= 1'b0;
         done_pulse <= 1'b0;
         wr_pend    <= 1'b0;
         wr_x       <= '0;
         wr_y       <= '0;
         for (int i = 0; i < DESC_WORDS; i++) dw[i] <= '0;
      end else begin
         done_pulse <= 1'b0;
         wr_pend    <= 1'b0;
         if (clear) begin
            state <= WS_IDLE;
            err   <= 1'b0;
         end else begin
            case (state)
               WS_IDLE: if (go) begin
                  if (go_ptr[3:0] != 4'h0) begin
                     err <= 1'b1;
                  end else begin
                     err   <= 1'b0;
                     ptr   <= go_ptr;
                     fcnt  <= '0;
                     state <= WS_FETCH;
                  end
               end
               WS_FETCH: begin
                  if (fcnt != 3'd0) dw[fcnt - 3'd1] <= mem_rd_data;
                  if (fcnt == LAST_W) state <= WS_CHECK;
                  else                fcnt  <= fcnt + 3'd1;
               end
               WS_CHECK: begin
                  if (desc_ok) begin
                     dptr  <= dw[4];
                     state <= WS_FILL;
                  end else begin
                     err   <= 1'b1;
                     state <= WS_IDLE;
                  end
               end
               WS_FILL: begin
                  dptr    <= dptr + 32'd4;
                  wr_pend <= 1'b1;
                  wr_x    <= cx;
                  wr_y    <= cy;
                  if (last) state <= WS_LAST;
               end
               WS_LAST: begin
                  if (dw[0] == 32'h0) begin
                     done_pulse <= 1'b1;
                     state      <= WS_IDLE;
                  end else if (dw[0][3:0] != 4'h0) begin
                     err   <= 1'b1;
                     state <= WS_IDLE;
                  end else begin
                     ptr   <= dw[0];
                     fcnt  <= '0;
                     state <= WS_FETCH;
                  end
               end
               default: state <= WS_IDLE;
            endcase
         end
      end
   end

   assign mem_rd_en   = (state == WS_FETCH && fcnt < LAST_W) || (state == WS_FILL);
   assign mem_rd_addr = (state == WS_FILL) ? dptr : ptr + {27'b0, fcnt, 2'b00};
   assign tbl_we      = wr_pend;
   assign tbl_id      = f_tid;
   assign tbl_addr    = {wr_y, wr_x};
   assign tbl_wdata   = mem_rd_data;
   assign ready       = (state == WS_IDLE);
   assign cur_ptr     = ptr;

   // R9: a clear leaves the engine idle with the write stream stopped
   assert_clear_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (ready && !tbl_we));
   // R7: every read issued lands on a word boundary
   assert_read_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00));
   // R6: a normal end never coincides with a fault
   assert_done_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (!err && ready));
   // R12: a pointer write while busy leaves the walk pointer untouched
   assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !ready && !clear && state != WS_LAST) |=> $stable(ptr));
endmodule

// File: rtl/tfill_regs.sv
module tfill_regs
   import tfill_pkg::*;
#(
   parameter int NUM_TABLES = 2,
   parameter bit IRQ_FLOP   = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        go,
   output logic        clear,
   input  logic        ready,
   input  logic        err,
   input  logic        done_pulse,
   input  logic [31:0] cur_ptr,
   output logic        irq
);
   logic [7:0]  irq_stat;
   logic [7:0]  irq_en;
   logic [7:0]  ack;
   logic        pend_any;
   logic [31:0] hwinfo;

   assign go    = reg_we && (reg_addr == RA_PTR) && (reg_wdata != 32'h0);
   assign clear = reg_we && (reg_addr == RA_PTR) && (reg_wdata == 32'h0);
   assign ack   = (reg_we && reg_addr == RA_IRQS) ? reg_wdata[7:0] : 8'h00;
   assign hwinfo = {3'b0, 5'd1, 3'b0, 5'(NUM_TABLES), 16'h0};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_stat <= '0;
         irq_en   <= '0;
      end else begin
         irq_stat <= (irq_stat & ~ack) | {7'b0, done_pulse};
         if (reg_we && reg_addr == RA_IRQE) irq_en <= reg_wdata[7:0];
      end
   end

   assign pend_any = |(irq_stat & irq_en);

   generate
      if (IRQ_FLOP) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pend_any;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = pend_any;
      end
   endgenerate

   always_comb begin
      case (reg_addr)
         RA_PTR:  reg_rdata = cur_ptr;
         RA_STAT: reg_rdata = {30'b0, err, ready};
         RA_IRQS: reg_rdata = {24'b0, irq_stat};
         RA_IRQE: reg_rdata = {24'b0, irq_en};
         RA_INFO: reg_rdata = hwinfo;
         default: reg_rdata = 32'h0;
      endcase
   end

   // R6: a chain completion raises the done bit unless acknowledged at once
   assert_done_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse && !reg_we) |=> irq_stat[IRQ_DONE]);
   // R11: a status bit written with 0 keeps its value
   assert_w1c_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_IRQS && !reg_wdata[0] && irq_stat[0]) |=> irq_stat[0]);
endmodule

// File: rtl/tfill_engine.sv
module tfill_engine
   import tfill_pkg::*;
#(
   parameter int XW         = 8,
   parameter int YW         = 7,
   parameter int TID_W      = 4,
   parameter int NUM_TABLES = 2,
   parameter bit IRQ_FLOP   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic             mem_rd_en,
   output logic [31:0]      mem_rd_addr,
   input  logic [31:0]      mem_rd_data,
   output logic             tbl_we,
   output logic [TID_W-1:0] tbl_id,
   output logic [XW+YW-1:0] tbl_addr,
   output logic [31:0]      tbl_wdata,
   output logic             irq
);
   generate
      if (XW < 1 || XW > 16) begin : g_bad_xw
         $error("XW must be 1..16");
      end
      if (YW < 1 || YW > 16) begin : g_bad_yw
         $error("YW must be 1..16");
      end
      if (TID_W < 1 || TID_W > 8) begin : g_bad_tid
         $error("TID_W must be 1..8");
      end
      if (NUM_TABLES < 1 || NUM_TABLES > 31 || NUM_TABLES > (1 << TID_W)) begin : g_bad_nt
         $error("NUM_TABLES out of range");
      end
   endgenerate

   logic        go, clear, ready, err, done_pulse;
   logic [31:0] cur_ptr;

   tfill_regs #(.NUM_TABLES(NUM_TABLES), .IRQ_FLOP(IRQ_FLOP)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .go         (go),
      .clear      (clear),
      .ready      (ready),
      .err        (err),
      .done_pulse (done_pulse),
      .cur_ptr    (cur_ptr),
      .irq        (irq)
   );

   tfill_walker #(.XW(XW), .YW(YW), .TID_W(TID_W), .NUM_TABLES(NUM_TABLES)) i_walker (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (go),
      .clear       (clear),
      .go_ptr      (reg_wdata),
      .mem_rd_en   (mem_rd_en),
      .mem_rd_addr (mem_rd_addr),
      .mem_rd_data (mem_rd_data),
      .tbl_we      (tbl_we),
      .tbl_id      (tbl_id),
      .tbl_addr    (tbl_addr),
      .tbl_wdata   (tbl_wdata),
      .ready       (ready),
      .err         (err),
      .done_pulse  (done_pulse),
      .cur_ptr     (cur_ptr)
   );
endmodule

// File: tb/test_tfill_engine.sv
module test_tfill_engine;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [15:0] x0;
      logic [15:0] y0;
      logic [15:0] x1;
      logic [15:0] y1;
      logic        st;
      logic [3:0]  tid;
      logic [11:0] dp;
      logic        bad;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{16'd0,   16'd0,   16'd3,   16'd1,   1'b1, 4'd1, 12'h100, 1'b0},
      '{16'd250, 16'd126, 16'd255, 16'd127, 1'b1, 4'd0, 12'h100, 1'b0},
      '{16'd5,   16'd5,   16'd5,   16'd5,   1'b1, 4'd1, 12'h100, 1'b0},
      '{16'd4,   16'd2,   16'd3,   16'd2,   1'b1, 4'd0, 12'h100, 1'b1},
      '{16'd0,   16'd0,   16'd1,   16'd128, 1'b1, 4'd0, 12'h100, 1'b1},
      '{16'd0,   16'd0,   16'd256, 16'd0,   1'b1, 4'd0, 12'h100, 1'b1},
      '{16'd1,   16'd1,   16'd2,   16'd2,   1'b0, 4'd0, 12'h100, 1'b1},
      '{16'd1,   16'd1,   16'd2,   16'd2,   1'b1, 4'd2, 12'h100, 1'b1},
      '{16'd1,   16'd1,   16'd2,   16'd2,   1'b1, 4'd0, 12'h108, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic [31:0] mem_rd_data;
   logic        tbl_we;
   logic [3:0]  tbl_id;
   logic [14:0] tbl_addr;
   logic [31:0] tbl_wdata;
   logic        irq;

   logic [31:0] mem [1024];
   logic [14:0] exp_addr [1024];
   logic [31:0] exp_data [1024];
   logic [3:0]  exp_tid  [1024];
   int exp_n = 0;
   int wr_cnt = 0;
   int checks = 0;
   int errors = 0;
   bit fin = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tfill_engine i_tfill_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_we      (reg_we),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .mem_rd_en   (mem_rd_en),
      .mem_rd_addr (mem_rd_addr),
      .mem_rd_data (mem_rd_data),
      .tbl_we      (tbl_we),
      .tbl_id      (tbl_id),
      .tbl_addr    (tbl_addr),
      .tbl_wdata   (tbl_wdata),
      .irq         (irq)
   );

   always_ff @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:2]];
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // R4: every table write is compared against the expected row-major stream
   always @(negedge clk) begin
      if (rst_n && tbl_we) begin
         if (wr_cnt < exp_n) begin
            chk(tbl_addr == exp_addr[wr_cnt], "R4 slot address", {17'b0, tbl_addr}, {17'b0, exp_addr[wr_cnt]});
            chk(tbl_wdata == exp_data[wr_cnt], "R4 entry data", tbl_wdata, exp_data[wr_cnt]);
            chk(tbl_id == exp_tid[wr_cnt], "R4 table id", {28'b0, tbl_id}, {28'b0, exp_tid[wr_cnt]});
         end else begin
            chk(1'b0, "R4/R7 unexpected table write", {17'b0, tbl_addr}, 32'hffffffff);
         end
         wr_cnt++;
      end
   end

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic put_desc(input int addr, input logic [31:0] nxt, input logic [15:0] x0, y0, x1, y1,
                           input logic st, input logic [3:0] tid, input logic [31:0] dp);
      mem[addr / 4]     = nxt;
      mem[addr / 4 + 1] = {y0, x0};
      mem[addr / 4 + 2] = {y1, x1};
      mem[addr / 4 + 3] = {20'b0, tid, 7'b0, st};
      mem[addr / 4 + 4] = dp;
   endtask

   task automatic build_exp(input int x0, y0, x1, y1, input logic [3:0] tid, input int dp, input logic [31:0] seed);
      int k = 0;
      for (int y = y0; y <= y1; y++) begin
         for (int x = x0; x <= x1; x++) begin
            mem[dp / 4 + k]  = seed + 32'(k);
            exp_addr[exp_n]  = 15'(y * 256 + x);
            exp_data[exp_n]  = seed + 32'(k);
            exp_tid[exp_n]   = tid;
            exp_n++;
            k++;
         end
      end
   endtask

   task automatic wait_ready();
      logic [31:0] s;
      repeat (3) @(posedge clk);
      for (int i = 0; i < 5000; i++) begin
         reg_read(3'd1, s);
         if (s[0]) break;
      end
      repeat (3) @(posedge clk);
   endtask

   task automatic finish_run();
      fin = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      int c;
      for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R1 reset state
      reg_read(3'd1, v); chk(v == 32'h1, "R1 status after reset", v, 32'h1);
      reg_read(3'd2, v); chk(v == 32'h0, "R1 irq status after reset", v, 32'h0);
      @(negedge clk); chk(irq == 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);
      chk(wr_cnt == 0, "R1 no writes after reset", 32'(wr_cnt), 32'h0);
      // R2 hardware info
      reg_read(3'd4, v); chk(v == 32'h0102_0000, "R2 hwinfo", v, 32'h0102_0000);

      // R3 R4 R6 R7: one-descriptor chains from the vector table
      for (int n = 0; n < NV; n++) begin
         exp_n = 0; wr_cnt = 0;
         put_desc(32'h040, 32'h0, VECS[n].x0, VECS[n].y0, VECS[n].x1, VECS[n].y1,
                  VECS[n].st, VECS[n].tid, {20'b0, VECS[n].dp});
         if (!VECS[n].bad)
            build_exp(VECS[n].x0, VECS[n].y0, VECS[n].x1, VECS[n].y1, VECS[n].tid,
                      {20'b0, VECS[n].dp}, 32'h1000_0000 + 32'(n) * 32'h100);
         reg_write(3'd2, 32'hff);
         reg_write(3'd0, 32'h040);
         wait_ready();
         chk(wr_cnt == exp_n, "R3/R4/R7 write count", 32'(wr_cnt), 32'(exp_n));
         reg_read(3'd1, v);
         chk(v == {30'b0, VECS[n].bad, 1'b1}, "R6/R7 status", v, {30'b0, VECS[n].bad, 1'b1});
         reg_read(3'd2, v);
         chk(v[0] == !VECS[n].bad, "R6/R7 done bit", v, {31'b0, !VECS[n].bad});
      end

      // R5 chain of two descriptors, R10 interrupt with enable
      exp_n = 0; wr_cnt = 0;
      put_desc(32'h040, 32'h080, 16'd2, 16'd3, 16'd4, 16'd3, 1'b1, 4'd1, 32'h100);
      put_desc(32'h080, 32'h000, 16'd10, 16'd20, 16'd11, 16'd21, 1'b1, 4'd0, 32'h200);
      build_exp(2, 3, 4, 3, 4'd1, 32'h100, 32'hAAAA_0000);
      build_exp(10, 20, 11, 21, 4'd0, 32'h200, 32'hBBBB_0000);
      reg_write(3'd2, 32'hff);
      reg_write(3'd3, 32'h01);
      @(negedge clk); chk(irq == 1'b0, "R10 no irq before done", {31'b0, irq}, 32'h0);
      reg_write(3'd0, 32'h040);
      wait_ready();
      chk(wr_cnt == 7, "R5 chain write count", 32'(wr_cnt), 32'd7);
      @(negedge clk); chk(irq == 1'b1, "R10 irq enabled and pending", {31'b0, irq}, 32'h1);
      reg_write(3'd3, 32'h00);
      @(negedge clk); chk(irq == 1'b0, "R10 irq masked", {31'b0, irq}, 32'h0);
      reg_read(3'd2, v); chk(v == 32'h1, "R10 masked bit still pending", v, 32'h1);
      reg_write(3'd3, 32'h01);
      reg_write(3'd2, 32'hfe);
      reg_read(3'd2, v); chk(v == 32'h1, "R11 write of 0 keeps bit", v, 32'h1);
      reg_write(3'd2, 32'h01);
      reg_read(3'd2, v); chk(v == 32'h0, "R11 write of 1 clears bit", v, 32'h0);
      @(negedge clk); chk(irq == 1'b0, "R10 irq low after ack", {31'b0, irq}, 32'h0);
      reg_write(3'd3, 32'h00);

      // R8 misaligned start pointer
      exp_n = 0; wr_cnt = 0;
      reg_write(3'd0, 32'h044);
      wait_ready();
      reg_read(3'd1, v); chk(v == 32'h3, "R8 misaligned start sets ERR", v, 32'h3);
      chk(wr_cnt == 0, "R8 misaligned start no writes", 32'(wr_cnt), 32'h0);

      // R8 misaligned next pointer
      exp_n = 0; wr_cnt = 0;
      put_desc(32'h040, 32'h088, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 4'd0, 32'h100);
      build_exp(0, 0, 0, 0, 4'd0, 32'h100, 32'hCCCC_0000);
      reg_write(3'd2, 32'hff);
      reg_write(3'd0, 32'h040);
      wait_ready();
      chk(wr_cnt == 1, "R8 first descriptor filled", 32'(wr_cnt), 32'h1);
      reg_read(3'd1, v); chk(v == 32'h3, "R8 bad next sets ERR", v, 32'h3);
      reg_read(3'd2, v); chk(v == 32'h0, "R8 bad next no done", v, 32'h0);

      // R9 abort by zero write in the middle of a long row
      exp_n = 0; wr_cnt = 0;
      put_desc(32'h0C0, 32'h0, 16'd0, 16'd0, 16'd255, 16'd0, 1'b1, 4'd1, 32'h800);
      build_exp(0, 0, 255, 0, 4'd1, 32'h800, 32'hDDDD_0000);
      reg_write(3'd0, 32'h0C0);
      repeat (40) @(posedge clk);
      reg_write(3'd0, 32'h0);
      repeat (2) @(posedge clk);
      c = wr_cnt;
      repeat (300) @(posedge clk);
      chk(wr_cnt == c, "R9 no writes after abort", 32'(wr_cnt), 32'(c));
      chk(c < 256, "R9 walk cut short", 32'(c), 32'd256);
      reg_read(3'd1, v); chk(v == 32'h1, "R9 ready and ERR clear after abort", v, 32'h1);
      reg_read(3'd2, v); chk(v == 32'h0, "R9 no done after abort", v, 32'h0);

      // R12 pointer write while busy is ignored
      exp_n = 0; wr_cnt = 0;
      build_exp(0, 0, 255, 0, 4'd1, 32'h800, 32'hEEEE_0000);
      reg_write(3'd0, 32'h0C0);
      repeat (20) @(posedge clk);
      reg_write(3'd0, 32'h040);
      wait_ready();
      chk(wr_cnt == 256, "R12 first walk completes", 32'(wr_cnt), 32'd256);
      reg_read(3'd0, v); chk(v == 32'h0C0, "R12 pointer unchanged", v, 32'h0C0);
      reg_read(3'd2, v); chk(v == 32'h1, "R12 done bit", v, 32'h1);

      finish_run();
   end
endmodule